// File: doc/BRIEF.md
# Biphase Input Sample-Rate Classifier

This block sits behind a biphase-mark serial audio input that has already been brought into a fast reference clock domain. Once per programmable window it looks at the gaps between transitions of that input. It picks one of seven sample-rate modes (32, 44.1, 48, 88.2, 96, 176.4 and 192 kHz, indices 0 to 6) or reports that no valid signal is present (mode 7). Software loads the window length and the per-mode timer and threshold words. Typically the window is the reference rate divided by 1000, which gives one decision per millisecond. Each timer is the reference rate over 128 times the mode's rate. Each threshold is the sum of two neighbouring timers.

Two measurements are offered. The default one takes the shortest transition gap seen in a window and places it between the thresholds. The other one matches that shortest gap directly against the timers. Alongside the mode, the block reports the longest gap of the last window and keeps a sticky status bit that is raised whenever the decided mode changes. That bit can drive an interrupt line through a mask.

Top module: `spdr_rate_classifier`

## Requirements
- R1: While `enable` is low, the block is held idle. One cycle later `mode_out` reads 7, `max_width` reads 0, `irq_status` reads 0 and `irq` is low. The first transition after enabling is measured correctly, whatever level `sin` had while idle.
- R2: A decision is taken in each cycle where the window count reaches `window_len`. A window therefore lasts `window_len` cycles, and a value of 0 behaves like 1. `mode_out` and `max_width` change only in the cycle after a decision.
- R3: A gap is the number of clock cycles between two successive transitions of `sin`. The first transition after enabling only starts the timing. Gaps longer than 1023 read as 1023.
- R4: `max_width` holds the longest gap that completed in the last window, and 0 if none completed.
- R5: With `width_sel` = 1, the mode is 1 plus the highest index i in 0..5 for which twice the shortest gap is below threshold i. If there is no such index, the mode is 0.
- R6: With `width_sel` = 0, the mode is the highest index i in 0..6 for which the shortest gap is no larger than timer i. If there is no such index, the mode is 7.
- R7: A window in which no gap completed decides mode 7.
- R8: Bit 2 of `irq_status` is set by a decision that differs from the previous mode. It stays set until it is cleared by writing a 1 to `irq_clear[2]`, and a set in the same cycle wins over a clear. All other status bits always read 0.
- R9: `irq` is high exactly when some bit is set in both `irq_status` and `irq_mask`.
- R10: Timer i is taken from bits [32*(i/4) + 8*(3 - i%4) +: 8] of `timer_bank`. Threshold i is taken from bits [32*(i/3) + 10*(2 - i%3) +: 10] of `thresh_bank`. In both banks the lowest mode of each 32-bit word sits in the most significant slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run enable; low holds the block idle |
| sin | input | 1 | Biphase-mark serial input, already synchronous to `clk` |
| width_sel | input | 1 | 1: threshold classification; 0: timer match |
| window_len | input | 20 | Decision window length in cycles |
| timer_bank | input | 64 | Seven 8-bit per-mode timers, packed four per word |
| thresh_bank | input | 64 | Six 10-bit per-mode thresholds, packed three per word |
| irq_mask | input | 8 | Interrupt enable per status bit |
| irq_clear | input | 8 | Write-one-to-clear strobe for status bits |
| mode_out | output | 3 | Decided mode, 7 meaning no valid signal |
| max_width | output | 10 | Longest gap of the last window |
| irq_status | output | 8 | Sticky status; bit 2 flags a mode change |
| irq | output | 1 | Masked interrupt request |

## Verification
Faults inside the block can show at the ports in a few ways. A wrong gap count or a lost arming flag shows up at the next decision, no later than one window after the fault, as a wrong `mode_out` or `max_width`. A window counter that drifts moves the decision cycles, so `mode_out` changes in a cycle where the reference model expects it to hold. The bench runs with a zero-length window so that every cycle decides, which exposes such errors within one cycle. A stale previous-mode register shows up as a missing or spurious `irq_status` bit 2 in the very cycle after the decision, and `irq` follows it at once.

// File: rtl/spdr_pkg.sv
package spdr_pkg;

    // Mode table shape
    localparam int NUM_MODES    = 7;
    localparam int NUM_THR      = NUM_MODES - 1;
    localparam int MODE_W       = 3;
    localparam logic [MODE_W-1:0] MODE_NONE = 3'd7;

    // Field widths
    localparam int WORD_W       = 32;
    localparam int TIMER_W      = 8;
    localparam int THR_W        = 10;
    localparam int WIDTH_W      = 10;
    localparam int IRQ_W        = 8;
    localparam int IRQ_MODE_BIT = 2;

    // Packing of the per-mode words
    localparam int TMR_PER_WORD = WORD_W / TIMER_W;
    localparam int THR_PER_WORD = WORD_W / THR_W;
    localparam int TMR_WORDS    = (NUM_MODES + TMR_PER_WORD - 1) / TMR_PER_WORD;
    localparam int THR_WORDS    = (NUM_THR + THR_PER_WORD - 1) / THR_PER_WORD;
    localparam int TMR_BANK_W   = TMR_WORDS * WORD_W;
    localparam int THR_BANK_W   = THR_WORDS * WORD_W;
    localparam int TMR_SPARE    = TMR_WORDS * TMR_PER_WORD - NUM_MODES;
    localparam int THR_PAD      = WORD_W - THR_PER_WORD * THR_W;

    typedef logic [MODE_W-1:0]  mode_t;
    typedef logic [WIDTH_W-1:0] width_t;

    localparam width_t WIDTH_MAX = '1;

    typedef enum logic {
        MEAS_TIMER_MATCH = 1'b0,
        MEAS_MIN_EDGE    = 1'b1
    } meas_sel_e;

    typedef struct packed {
        logic   valid;
        width_t min_w;
        width_t max_w;
    } win_meas_t;

    // Bit position of entry idx inside a bank; lowest index in the top slot
    function automatic int slot_lsb(input int idx, input int per_word, input int field_w);
        return WORD_W * (idx / per_word) + field_w * (per_word - 1 - (idx % per_word));
    endfunction

endpackage

// File: rtl/spdr_window_timer.sv
module spdr_window_timer
    import spdr_pkg::*;
#(
    parameter int WIN_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [WIN_W-1:0] len,
    output logic             tick
);

    logic [WIN_W-1:0] cnt_q;
    logic [WIN_W:0]   cnt_next;

    assign cnt_next = {1'b0, cnt_q} + 1'b1;
    assign tick     = run && (cnt_next >= {1'b0, len});

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_next[WIN_W-1:0];
        end
    end

endmodule

// File: rtl/spdr_edge_meter.sv
module spdr_edge_meter
    import spdr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      sin,
    input  logic      tick,
    output win_meas_t fin
);

    localparam win_meas_t EMPTY = '{valid: 1'b0, min_w: WIDTH_MAX, max_w: '0};

    logic      sin_q;
    logic      armed_q;
    width_t    since_q;
    win_meas_t acc_q;
    logic      edge_seen;
    logic      got;
    width_t    gap;

    assign edge_seen = sin ^ sin_q;
    assign got       = edge_seen & armed_q;
    assign gap       = (since_q == WIDTH_MAX) ? WIDTH_MAX : since_q + 1'b1;

    // Window result including a gap that completes in this very cycle
    always_comb begin
        fin = acc_q;
        if (got) begin
            fin.valid = 1'b1;
            if (!acc_q.valid || gap < acc_q.min_w) fin.min_w = gap;
            if (!acc_q.valid || gap > acc_q.max_w) fin.max_w = gap;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sin_q   <= sin;
            armed_q <= 1'b0;
            since_q <= '0;
            acc_q   <= EMPTY;
        end else begin
            sin_q <= sin;
            if (edge_seen) begin
                armed_q <= 1'b1;
                since_q <= '0;
            end else if (since_q != WIDTH_MAX) begin
                since_q <= since_q + 1'b1;
            end
            acc_q <= tick ? EMPTY : fin;
        end
    end

endmodule

// File: rtl/spdr_mode_decider.sv
module spdr_mode_decider
    import spdr_pkg::*;
(
    input  meas_sel_e               sel,
    input  logic                    valid,
    input  width_t                  min_w,
    input  logic [TMR_BANK_W-1:0]   timer_bank,
    input  logic [THR_BANK_W-1:0]   thresh_bank,
    output mode_t                   mode
);

    logic [TIMER_W-1:0] tmr [NUM_MODES];
    logic [THR_W-1:0]   thr [NUM_THR];
    logic [WIDTH_W:0]   twice;
    mode_t              by_thr;
    mode_t              by_tmr;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_MODES; gi++) begin : g_tmr
            assign tmr[gi] = timer_bank[slot_lsb(gi, TMR_PER_WORD, TIMER_W) +: TIMER_W];
        end
        for (gi = 0; gi < NUM_THR; gi++) begin : g_thr
            assign thr[gi] = thresh_bank[slot_lsb(gi, THR_PER_WORD, THR_W) +: THR_W];
        end
        if (TMR_SPARE > 0) begin : g_tmr_spare
            logic unused_tmr_slots;
            assign unused_tmr_slots = ^timer_bank[WORD_W*(TMR_WORDS-1) +: TIMER_W*TMR_SPARE];
        end
        if (THR_PAD > 0) begin : g_thr_pad
            logic [THR_WORDS-1:0] unused_thr_pad;
            for (gi = 0; gi < THR_WORDS; gi++) begin : g_word
                assign unused_thr_pad[gi] = ^thresh_bank[WORD_W*gi + THR_PER_WORD*THR_W +: THR_PAD];
            end
        end
    endgenerate

    assign twice = {min_w, 1'b0};

    always_comb begin
        by_thr = '0;
        for (int i = 0; i < NUM_THR; i++) begin
            if (twice < {1'b0, thr[i]}) by_thr = mode_t'(i + 1);
        end
        by_tmr = MODE_NONE;
        for (int i = 0; i < NUM_MODES; i++) begin
            if (min_w <= width_t'(tmr[i])) by_tmr = mode_t'(i);
        end
    end

    assign mode = !valid ? MODE_NONE : ((sel == MEAS_MIN_EDGE) ? by_thr : by_tmr);

endmodule

// File: rtl/spdr_rate_classifier.sv
module spdr_rate_classifier
    import spdr_pkg::*;
#(
    parameter int WIN_W = 20
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic                  sin,
    input  logic                  width_sel,
    input  logic [WIN_W-1:0]      window_len,
    input  logic [TMR_BANK_W-1:0] timer_bank,
    input  logic [THR_BANK_W-1:0] thresh_bank,
    input  logic [IRQ_W-1:0]      irq_mask,
    input  logic [IRQ_W-1:0]      irq_clear,
    output logic [MODE_W-1:0]     mode_out,
    output logic [WIDTH_W-1:0]    max_width,
    output logic [IRQ_W-1:0]      irq_status,
    output logic                  irq
);

    logic             win_tick;
    win_meas_t        fin;
    mode_t            next_mode;
    mode_t            mode_q;
    width_t           maxw_q;
    logic [IRQ_W-1:0] stat_q;
    logic [IRQ_W-1:0] set_vec;
    logic             change;

    spdr_window_timer #(.WIN_W(WIN_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (enable),
        .len  (window_len),
        .tick (win_tick)
    );

    spdr_edge_meter u_meter (
        .clk  (clk),
        .rst  (rst),
        .run  (enable),
        .sin  (sin),
        .tick (win_tick),
        .fin  (fin)
    );

    spdr_mode_decider u_decide (
        .sel         (meas_sel_e'(width_sel)),
        .valid       (fin.valid),
        .min_w       (fin.min_w),
        .timer_bank  (timer_bank),
        .thresh_bank (thresh_bank),
        .mode        (next_mode)
    );

    assign change  = win_tick && (next_mode != mode_q);
    assign set_vec = change ? (IRQ_W'(1) << IRQ_MODE_BIT) : '0;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            mode_q <= MODE_NONE;
            maxw_q <= '0;
            stat_q <= '0;
        end else begin
            if (win_tick) begin
                mode_q <= next_mode;
                maxw_q <= fin.valid ? fin.max_w : '0;
            end
            stat_q <= (stat_q & ~irq_clear) | set_vec;
        end
    end

    assign mode_out   = mode_q;
    assign max_width  = maxw_q;
    assign irq_status = stat_q;
    assign irq        = |(stat_q & irq_mask);

endmodule

// File: rtl/spdr_rate_checker.sv
module spdr_rate_checker
    import spdr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               enable,
    input logic               win_tick,
    input logic [MODE_W-1:0]  mode_out,
    input logic [WIDTH_W-1:0] max_width,
    input logic [IRQ_W-1:0]   irq_status
);

    assert_disabled_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (mode_out == MODE_NONE && max_width == '0 && irq_status == '0));

    assert_mode_held_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(enable) && !$past(rst) && !$past(win_tick)) |-> $stable(mode_out));

    assert_only_mode_bit_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_status & ~(IRQ_W'(1) << IRQ_MODE_BIT)) == '0);

    assert_change_flags_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(enable) && !$past(rst) && !$stable(mode_out)) |-> irq_status[IRQ_MODE_BIT]);

    assert_mode_needs_gap_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_out != MODE_NONE) |-> (max_width != '0));

endmodule

bind spdr_rate_classifier spdr_rate_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .win_tick   (win_tick),
    .mode_out   (mode_out),
    .max_width  (max_width),
    .irq_status (irq_status)
);

// File: tb/spdr_rate_classifier_test.sv
module spdr_rate_classifier_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        sin = 1'b0;
    logic        width_sel = 1'b1;
    logic [19:0] window_len = 20'd600;
    logic [63:0] timer_bank = '0;
    logic [63:0] thresh_bank = '0;
    logic [7:0]  irq_mask = '0;
    logic [7:0]  irq_clear = '0;
    logic [2:0]  mode_out;
    logic [9:0]  max_width;
    logic [7:0]  irq_status;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;
    bit done = 0;

    int tmr [7] = '{81, 59, 54, 29, 27, 14, 13};
    int thr [6];

    always #5 clk = ~clk;

    spdr_rate_classifier uut (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .sin         (sin),
        .width_sel   (width_sel),
        .window_len  (window_len),
        .timer_bank  (timer_bank),
        .thresh_bank (thresh_bank),
        .irq_mask    (irq_mask),
        .irq_clear   (irq_clear),
        .mode_out    (mode_out),
        .max_width   (max_width),
        .irq_status  (irq_status),
        .irq         (irq)
    );

    task automatic chk(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Pattern generator: gaps of t, t, 2t repeating; gen_t == 0 holds the line
    int gen_t = 0;
    int gcnt = 0;
    int gidx = 0;
    always @(negedge clk) begin
        #1;
        if (gen_t == 0) begin
            gcnt = 0;
        end else begin
            gcnt++;
            if (gcnt >= ((gidx == 2) ? 2 * gen_t : gen_t)) begin
                sin = ~sin;
                gcnt = 0;
                gidx = (gidx + 1) % 3;
            end
        end
    end

    // Behavioural reference model
    int m_prev = 0, m_armed = 0, m_since = 0, m_win = 0;
    int m_any = 0, m_min = 0, m_max = 0;
    int e_mode = 7, e_maxw = 0, e_stat = 0;

    function automatic int ref_mode(input int w, input logic sel);
        int m;
        if (sel) begin
            m = 0;
            for (int i = 0; i < 6; i++) if (2 * w < thr[i]) m = i + 1;
        end else begin
            m = 7;
            for (int i = 0; i < 7; i++) if (w <= tmr[i]) m = i;
        end
        return m;
    endfunction

    always @(posedge clk) begin
        int w;
        int nm;
        int setb;
        if (rst || !enable) begin
            m_prev = sin; m_armed = 0; m_since = 0; m_win = 0;
            m_any = 0; m_min = 0; m_max = 0;
            e_mode = 7; e_maxw = 0; e_stat = 0;
        end else begin
            setb = 0;
            if (sin != m_prev) begin
                if (m_armed != 0) begin
                    w = (m_since + 1 > 1023) ? 1023 : m_since + 1;
                    if (m_any == 0 || w < m_min) m_min = w;
                    if (m_any == 0 || w > m_max) m_max = w;
                    m_any = 1;
                end
                m_armed = 1;
                m_since = 0;
            end else if (m_since < 100000) begin
                m_since++;
            end
            m_prev = sin;
            if (m_win + 1 >= int'(window_len)) begin
                nm = (m_any != 0) ? ref_mode(m_min, width_sel) : 7;
                if (nm != e_mode) setb = 1;
                e_mode = nm;
                e_maxw = (m_any != 0) ? m_max : 0;
                m_any = 0; m_min = 0; m_max = 0;
                m_win = 0;
            end else begin
                m_win++;
            end
            e_stat = (e_stat & ~int'(irq_clear)) | (setb != 0 ? 4 : 0);
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk(int'(mode_out), e_mode, "mode per cycle (R2 R5 R6 R7)");
            chk(int'(max_width), e_maxw, "max width per cycle (R3 R4)");
            chk(int'(irq_status), e_stat, "status per cycle (R1 R8)");
            chk(int'(irq), ((e_stat & int'(irq_mask)) != 0) ? 1 : 0, "irq per cycle (R9)");
        end
    end

    task automatic clear_status();
        #1 irq_clear = 8'hFF;
        @(negedge clk);
        #1 irq_clear = 8'h00;
        @(negedge clk);
        chk(int'(irq_status), 0, "R8 status after clear");
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (R2): actual timeout expected completion");
        finish_run();
    end

    initial begin
        int nz;
        for (int i = 0; i < 6; i++) thr[i] = tmr[i] + tmr[i + 1];
        for (int i = 0; i < 7; i++)
            timer_bank[32 * (i / 4) + 8 * (3 - i % 4) +: 8] = 8'(tmr[i]);
        for (int i = 0; i < 6; i++)
            thresh_bank[32 * (i / 3) + 10 * (2 - i % 3) +: 10] = 10'(thr[i]);

        @(posedge clk);
        #1 cmp_on = 1;
        repeat (4) @(negedge clk);
        chk(int'(mode_out), 7, "R1 reset mode");
        chk(int'(max_width), 0, "R1 reset max width");
        chk(int'(irq_status), 0, "R1 reset status");
        chk(int'(irq), 0, "R1 reset irq");

        #1 rst = 0; enable = 1; sin = 1'b1;
        repeat (1300) @(negedge clk);
        chk(int'(mode_out), 7, "R7 idle line mode");
        chk(int'(max_width), 0, "R4 idle line max width");
        chk(int'(irq_status), 0, "R8 no change no flag");

        // Threshold classification across every mode (also exercises R10 packing)
        for (int k = 0; k < 7; k++) begin
            #1 gen_t = tmr[k];
            repeat (2400) @(negedge clk);
            chk(int'(mode_out), k, "R5 R10 threshold mode");
            chk(int'(max_width), 2 * tmr[k], "R4 longest gap");
            chk(int'(irq_status[2]), 1, "R8 change flag");
            clear_status();
        end

        // Mask gating
        #1 irq_mask = 8'h04; gen_t = 81;
        repeat (2400) @(negedge clk);
        chk(int'(irq), 1, "R9 unmasked irq");
        #1 irq_mask = 8'hFB;
        @(negedge clk);
        chk(int'(irq), 0, "R9 masked irq");
        clear_status();

        // Timer-match measurement (R10 timer packing)
        #1 width_sel = 1'b0; gen_t = 54;
        repeat (2400) @(negedge clk);
        chk(int'(mode_out), 2, "R6 R10 timer match");
        #1 gen_t = 90;
        repeat (2400) @(negedge clk);
        chk(int'(mode_out), 7, "R6 no timer match");
        chk(int'(max_width), 180, "R4 longest gap timer mode");

        // Line goes quiet
        #1 width_sel = 1'b1; gen_t = 0;
        repeat (1300) @(negedge clk);
        chk(int'(mode_out), 7, "R7 lost signal");
        chk(int'(max_width), 0, "R4 nothing captured");

        // Saturating gaps
        #1 window_len = 20'd3000; gen_t = 1100;
        repeat (12000) @(negedge clk);
        chk(int'(max_width), 1023, "R3 saturated gap");
        chk(int'(mode_out), 0, "R3 saturated gap mode");

        // Zero-length window: decision every cycle
        #1 window_len = 20'd0; gen_t = 13;
        repeat (80) @(negedge clk);
        nz = 0;
        for (int c = 0; c < 364; c++) begin
            @(negedge clk);
            if (mode_out != 3'd7) nz++;
        end
        chk(nz, 21, "R2 per-cycle decisions");

        // Disable mid-stream
        #1 irq_mask = 8'hFF; enable = 1'b0;
        repeat (2) @(negedge clk);
        chk(int'(mode_out), 7, "R1 disabled mode");
        chk(int'(max_width), 0, "R1 disabled max width");
        chk(int'(irq_status), 0, "R1 disabled status");
        chk(int'(irq), 0, "R1 disabled irq");

        finish_run();
    end

endmodule